// File: doc/BRIEF.md
# Power Mode Controller

This block holds the power-mode control register of an 8-bit microcontroller core and turns its contents into two clock enables: one for the instruction-executing core and one for the peripherals. The peripherals are the timers, the serial port and the interrupt logic. Software writes the register through a special-function-register port at one fixed address. Setting the idle bit stops only the core clock. Setting the power-down bit stops both clocks, and register contents are kept. A set mode bit takes effect at the next instruction boundary, which the core marks with a strobe.

A pending interrupt ends idle. The hardware clears the idle bit and the core clock resumes, so the interrupt can be serviced. Interrupts cannot end power-down, because no clock is left to sample them. Only a qualified reset ends it. The reset request input must stay high for a whole number of machine cycles before it counts. A qualified reset clears the register and restores both clock enables.

Top module: `pwr_ctl_unit`

## Requirements
- R1: After the asynchronous reset is applied, `cpu_clk_en` and `per_clk_en` are both 1 and the register reads 0x00.
- R2: A write with `sfr_addr` equal to 0x87 loads the register on the next clock edge. The bit positions are: bit 7 double-rate, bit 3 flag B, bit 2 flag A, bit 1 power-down, bit 0 idle. A write to any other address leaves the register unchanged.
- R3: When `sfr_addr` is 0x87, `sfr_rdata` shows the register, and reserved bits 6 to 4 read as 0. At any other address, `sfr_rdata` is 0x00.
- R4: A set mode bit does not change either clock enable until a clock edge at which `insn_end` is high. From the cycle after that edge, the mode is in force.
- R5: A write that sets bits 1 and 0 together stores power-down = 1 and idle = 0.
- R6: In idle, `cpu_clk_en` is 0 and `per_clk_en` stays 1.
- R7: In power-down, both enables are 0. Interrupts have no effect on the enables or on the register while in power-down.
- R8: In idle, `irq_pending` high at a clock edge clears the idle bit and sets `cpu_clk_en` back to 1 from the next cycle.
- R9: `core_rst` rises after `rst_req` has been high for CLKS_PER_MC*HOLD_MC consecutive edges (24 by default). At the following edge, the register clears and both enables return to 1, including from power-down. A shorter pulse has no effect.
- R10: `dbl_rate` always equals register bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_req | input | 1 | Unqualified reset request from the reset pin |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Special-function-register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for the addressed register |
| insn_end | input | 1 | Instruction-boundary strobe from the core |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | Clock enable for the core |
| per_clk_en | output | 1 | Clock enable for the peripherals |
| dbl_rate | output | 1 | Double-rate select for the serial port |
| core_rst | output | 1 | Qualified reset |

## Verification
Getting out of power-down is the hardest case to reach from the ports. The clocks stay off and interrupts are ignored, so only a reset request held for the full qualifying window can end it. The stimulus first enters power-down with the flags and the double-rate bit set. It then applies interrupts and a request one cycle short of the window, and confirms nothing moved. Finally it holds the request for the full window and checks the exact edge where the qualified reset rises and the edge where the enables come back.

// File: rtl/pcon_pkg.sv
package pcon_pkg;
  typedef struct packed {
    logic dbl;
    logic flg_b;
    logic flg_a;
    logic pd;
    logic idl;
  } pcon_t;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;

  localparam int BIT_DBL = 7;
  localparam int BIT_FLB = 3;
  localparam int BIT_FLA = 2;
  localparam int BIT_PD  = 1;
  localparam int BIT_IDL = 0;

  function automatic logic [7:0] pcon_to_byte(pcon_t r);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_DBL] = r.dbl;
    b[BIT_FLB] = r.flg_b;
    b[BIT_FLA] = r.flg_a;
    b[BIT_PD]  = r.pd;
    b[BIT_IDL] = r.idl;
    return b;
  endfunction
endpackage

// File: rtl/pcon_rst_qual.sv
module pcon_rst_qual #(
  parameter int CLKS_PER_MC = 12,
  parameter int HOLD_MC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  output logic core_rst
);
  localparam int TARGET = CLKS_PER_MC * HOLD_MC;
  localparam int CW     = $clog2(TARGET + 1);
  localparam logic [CW-1:0] TGT = CW'(TARGET);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!rst_req)        cnt_d = '0;
    else if (cnt_q != TGT) cnt_d = cnt_q + 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign core_rst = (cnt_q == TGT);
endmodule

// File: rtl/pcon_regfile.sv
module pcon_regfile
  import pcon_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              idle_clr,
  output pcon_t             reg_q,
  output logic [7:0]        sfr_rdata
);
  logic  hit;
  pcon_t reg_d;

  assign hit = (sfr_addr == SFR_ADDR);

  always_comb begin
    reg_d = reg_q;
    if (core_rst) begin
      reg_d = '0;
    end else if (sfr_wr && hit) begin
      reg_d.dbl   = sfr_wdata[BIT_DBL];
      reg_d.flg_b = sfr_wdata[BIT_FLB];
      reg_d.flg_a = sfr_wdata[BIT_FLA];
      reg_d.pd    = sfr_wdata[BIT_PD];
      reg_d.idl   = sfr_wdata[BIT_IDL] & ~sfr_wdata[BIT_PD];
    end else if (idle_clr) begin
      reg_d.idl = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign sfr_rdata = hit ? pcon_to_byte(reg_q) : 8'h00;
endmodule

// File: rtl/pcon_gate.sv
module pcon_gate
  import pcon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  core_rst,
  input  logic  insn_end,
  input  logic  irq_pending,
  input  logic  pd_bit,
  input  logic  idl_bit,
  output logic  idle_clr,
  output logic  cpu_clk_en,
  output logic  per_clk_en
);
  pmode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (core_rst) begin
      mode_d = PM_RUN;
    end else begin
      unique case (mode_q)
        PM_RUN: begin
          if (insn_end && pd_bit)       mode_d = PM_DOWN;
          else if (insn_end && idl_bit) mode_d = PM_IDLE;
        end
        PM_IDLE: if (irq_pending) mode_d = PM_RUN;
        PM_DOWN: mode_d = PM_DOWN;
        default: mode_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end

  assign idle_clr   = (mode_q == PM_IDLE) && irq_pending && !core_rst;
  assign cpu_clk_en = (mode_q == PM_RUN);
  assign per_clk_en = (mode_q != PM_DOWN);
endmodule

// File: rtl/pwr_ctl_unit.sv
module pwr_ctl_unit
  import pcon_pkg::*;
#(
  parameter int        ADDR_W      = 8,
  parameter logic [7:0] SFR_ADDR   = 8'h87,
  parameter int        CLKS_PER_MC = 12,
  parameter int        HOLD_MC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_req,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       insn_end,
  input  logic       irq_pending,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       dbl_rate,
  output logic       core_rst
);
  pcon_t reg_q;
  logic  idle_clr;

  pcon_rst_qual #(.CLKS_PER_MC(CLKS_PER_MC), .HOLD_MC(HOLD_MC)) u_qual (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .core_rst(core_rst)
  );

  pcon_regfile #(.ADDR_W(ADDR_W), .SFR_ADDR(SFR_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .idle_clr(idle_clr),
    .reg_q(reg_q), .sfr_rdata(sfr_rdata)
  );

  pcon_gate u_gate (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .insn_end(insn_end),
    .irq_pending(irq_pending), .pd_bit(reg_q.pd), .idl_bit(reg_q.idl),
    .idle_clr(idle_clr), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en)
  );

  assign dbl_rate = reg_q.dbl;
endmodule

// File: rtl/pcon_chk.sv
module pcon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_end,
  input logic       irq_pending,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       core_rst,
  input logic [7:0] sfr_rdata
);
  assert_down_both_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> !cpu_clk_en);

  assert_down_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_clk_en && !core_rst) |=> !per_clk_en);

  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && irq_pending) |=> cpu_clk_en);

  assert_gate_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> $past(insn_end));

  assert_reset_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (cpu_clk_en && per_clk_en));

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata[6:4] == 3'b000);
endmodule

bind pwr_ctl_unit pcon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .irq_pending(irq_pending),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .core_rst(core_rst),
  .sfr_rdata(sfr_rdata)
);

// File: tb/sim_pwr_ctl_unit.sv
`timescale 1ns/1ps
module sim_pwr_ctl_unit;
  logic       clk = 1'b0;
  logic       rst_n, rst_req, sfr_wr, insn_end, irq_pending;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       cpu_clk_en, per_clk_en, dbl_rate, core_rst;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_ctl_unit u0 (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .insn_end(insn_end), .irq_pending(irq_pending), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .dbl_rate(dbl_rate), .core_rst(core_rst)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    tick();
    sfr_wr = 1'b0; sfr_addr = 8'h87;
  endtask

  task automatic enables(string req, logic c, logic p);
    chk(req, {6'd0, cpu_clk_en, per_clk_en}, {6'd0, c, p});
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_req = 1'b0; sfr_wr = 1'b0; sfr_addr = 8'h87;
    sfr_wdata = 8'h00; insn_end = 1'b0; irq_pending = 1'b0;
    #9; rst_n = 1'b1;
    tick();
    // R1 reset state
    enables("R1", 1'b1, 1'b1);
    chk("R1", sfr_rdata, 8'h00);

    // R2/R3/R5/R10 sweep of every write value, no boundary strobe
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d, e;
      d = 8'(v);
      e = (d & 8'h8C) | (d[1] ? 8'h02 : {7'd0, d[0]});
      wr(8'h87, d);
      chk("R2_R3_R5", sfr_rdata, e);
      chk("R10", {7'd0, dbl_rate}, {7'd0, d[7]});
      enables("R4", 1'b1, 1'b1);
    end

    // R2/R3 other addresses ignored and read zero
    wr(8'h87, 8'h84);
    for (int a = 0; a < 256; a += 7) begin
      if (a != 8'h87) begin
        wr(8'(a), 8'hFF);
        sfr_addr = 8'(a); #1;
        chk("R3", sfr_rdata, 8'h00);
        sfr_addr = 8'h87; #1;
        chk("R2", sfr_rdata, 8'h84);
      end
    end

    // R4 / R6 / R8 idle entry and wake
    wr(8'h87, 8'h05);
    tick(); tick();
    enables("R4", 1'b1, 1'b1);
    insn_end = 1'b1; tick(); insn_end = 1'b0;
    enables("R6", 1'b0, 1'b1);
    tick(); tick();
    enables("R6", 1'b0, 1'b1);
    chk("R6", sfr_rdata, 8'h05);
    irq_pending = 1'b1; tick(); irq_pending = 1'b0;
    enables("R8", 1'b1, 1'b1);
    chk("R8", sfr_rdata, 8'h04);

    // R5 / R7 power-down with flags, interrupts ignored
    wr(8'h87, 8'h8F);
    chk("R5", sfr_rdata, 8'h8E);
    insn_end = 1'b1; tick(); insn_end = 1'b0;
    enables("R7", 1'b0, 1'b0);
    irq_pending = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    irq_pending = 1'b0;
    enables("R7", 1'b0, 1'b0);
    chk("R7", sfr_rdata, 8'h8E);

    // R9 short request ignored
    rst_req = 1'b1;
    for (int i = 0; i < 23; i++) tick();
    chk("R9", {7'd0, core_rst}, 8'h00);
    rst_req = 1'b0; tick();
    enables("R9", 1'b0, 1'b0);
    chk("R9", sfr_rdata, 8'h8E);

    // R9 full request ends power-down
    rst_req = 1'b1;
    for (int i = 0; i < 24; i++) tick();
    chk("R9", {7'd0, core_rst}, 8'h01);
    enables("R9", 1'b0, 1'b0);
    tick();
    enables("R9", 1'b1, 1'b1);
    chk("R9", sfr_rdata, 8'h00);
    chk("R10", {7'd0, dbl_rate}, 8'h00);
    rst_req = 1'b0; tick();
    chk("R9", {7'd0, core_rst}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule